// File: doc/BRIEF.md
# Multichannel ADC Frame Acquisition Sequencer

This block is the host side of the serial link to an eight-channel delta-sigma converter whose output buffer holds two conversions. Coming out of reset, it first pulses a sync line that several converters share, so that they all restart their conversions together. It then reads two complete dummy frames back to back, which leaves the converter buffer empty. From that point on it waits for falling edges on the active-low data-ready input. On each edge it clocks in one frame and hands every word to the parent logic on a parallel bus, together with a single-cycle valid pulse and the word's position in the frame.

A frame is made of one response word and then one word per channel, each word WORD_W bits wide. The converter would also send a trailing checksum word. The sequencer raises chip select before that word, so it is never clocked. The response word of the first frame read after the sync pulse carries a status bit that confirms the converter resynchronized. If that bit is clear, a sticky error flag is set. A second sticky flag records a data-ready falling edge that arrives while a frame is still being read, which means the converter buffer has started to back up.

Top module: `adc_frame_seq`

## Requirements
- R1: While rstN is low, syncN and csN are high, sclk is low, wordValid is low, and resyncErr and overrun are low.
- R2: After reset release, syncN goes low for exactly SYNC_LO_CYC clock cycles, then high for exactly SYNC_HI_CYC cycles, then low for SYNC_LO_CYC cycles again. After that it stays high until the next reset.
- R3: After the sync pattern, the block reads two dummy frames back to back. Each has csN low for exactly (CH_N+1)*WORD_W sclk falling edges, and csN goes high between the two frames. No wordValid pulse occurs during either dummy frame.
- R4: Bit RESYNC_BIT (default 10) of the response word in the first dummy frame sets resyncErr when it is 0. resyncErr stays set until reset. Response words in later frames never change resyncErr.
- R5: Once the dummy frames are done, a falling edge of drdyN seen while no frame is in progress starts exactly one frame. In that frame csN is low for (CH_N+1)*WORD_W sclk falling edges, so the checksum word is never clocked.
- R6: Each acquisition frame produces CH_N+1 single-cycle wordValid pulses. wordIdx is 0 for the response word and 1 to CH_N for the channel words, in the order they arrive. wordData equals the bits shifted in, most significant bit first.
- R7: The serial link uses SPI mode 1. sclk is low whenever csN is high. The block samples miso on the falling edge of sclk, after the converter has changed it on the rising edge.
- R8: Falling edges of drdyN during the sync pattern or during the dummy frames start no frame and do not set overrun.
- R9: A falling edge of drdyN while an acquisition frame is being read sets overrun, which stays set until reset. The frame in progress still completes with all CH_N+1 words, and later frames are read normally.
- R10: Holding drdyN low starts only one frame. A new frame needs a new falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| drdyN | input | 1 | Converter data-ready, active low, asynchronous |
| miso | input | 1 | Serial data from the converter |
| syncN | output | 1 | Shared active-low sync line |
| csN | output | 1 | Active-low chip select, held low for a whole frame |
| sclk | output | 1 | Serial clock, idles low |
| wordData | output | WORD_W | Word just received |
| wordIdx | output | $clog2(CH_N+1) | Position of the word in the frame, 0 for the response word |
| wordValid | output | 1 | One-cycle strobe for wordData and wordIdx |
| resyncErr | output | 1 | Sticky: resync confirmation bit was clear |
| overrun | output | 1 | Sticky: data-ready fell during a frame |

## Verification
The bench models the converter on the serial pins and measures the sync pulse widths cycle by cycle. An off-by-one counter would show up as a pulse one cycle too short or too long. It counts serial clock edges per frame, which exposes a design that clocks the checksum word or drops a bit, and it uses all-ones, alternating and single-bit patterns to catch a sampling edge that is in the wrong place or a shift that runs in the wrong direction. It puts data-ready edges inside the startup window and inside a running frame, where a faulty design would start an extra read or fail to flag the overrun. It also holds data-ready low for longer than a whole frame, where a level-triggered design would read twice. It runs one start-up with the resync bit clear and one with it set, with later response words always clear, so a design that ignores the bit, or checks it on the wrong frame, shows up.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  // Strobes from the sequencer to the shift datapath
  typedef struct packed {
    logic wordStart;  // begin shifting one word
    logic emit;       // finished words leave the block
  } dpCmd_t;

  typedef enum logic [2:0] {
    S_BOOT,
    S_SYNC_A,
    S_SYNC_B,
    S_SYNC_C,
    S_FLUSH,
    S_GAP,
    S_IDLE,
    S_FRAME
  } seqState_t;

endpackage

// File: rtl/adc_seq_shift.sv
module adc_seq_shift
  import adc_seq_pkg::*;
#(
  parameter int WORD_W    = 24,
  parameter int SCLK_HALF = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic              miso,
  output logic              sclk,
  output logic [WORD_W-1:0] word,
  output logic              done
);

  localparam int DIV_W = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
  localparam int BIT_W = $clog2(WORD_W);

  logic              active;
  logic [DIV_W-1:0]  divCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic [WORD_W-1:0] shReg;
  logic              sclkR;
  logic              doneR;
  logic [WORD_W-1:0] wordR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0;
      divCnt <= '0;
      bitCnt <= '0;
      shReg  <= '0;
      sclkR  <= 1'b0;
      doneR  <= 1'b0;
      wordR  <= '0;
    end else begin
      doneR <= 1'b0;
      if (cmd.wordStart) begin
        active <= 1'b1;
        divCnt <= '0;
        bitCnt <= '0;
        sclkR  <= 1'b0;
      end else if (active) begin
        if (divCnt == DIV_W'(SCLK_HALF - 1)) begin
          divCnt <= '0;
          sclkR  <= ~sclkR;
          if (sclkR) begin
            // falling edge: converter data settled since the rising edge
            shReg <= {shReg[WORD_W-2:0], miso};
            if (bitCnt == BIT_W'(WORD_W - 1)) begin
              active <= 1'b0;
              doneR  <= 1'b1;
              wordR  <= {shReg[WORD_W-2:0], miso};
              bitCnt <= '0;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
    end
  end

  assign sclk = sclkR;
  assign word = wordR;
  assign done = doneR;

  // R5
  start_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.wordStart |-> !active);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneR |=> !doneR);

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CH_N        = 8,
  parameter int SYNC_LO_CYC = 4,
  parameter int SYNC_HI_CYC = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        drdyN,
  input  logic                        dpDone,
  input  logic                        respBit,
  output dpCmd_t                      cmd,
  output logic                        syncN,
  output logic                        csN,
  output logic [$clog2(CH_N+1)-1:0]   wordIdx,
  output logic                        resyncErr,
  output logic                        overrun
);

  localparam int FRAME_W = CH_N + 1;
  localparam int IDX_W   = $clog2(FRAME_W);
  localparam int SYNC_MX = (SYNC_LO_CYC > SYNC_HI_CYC) ? SYNC_LO_CYC : SYNC_HI_CYC;
  localparam int CNT_W   = $clog2(SYNC_MX + 1);

  seqState_t        state;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] wordCnt;
  logic             flushCnt;
  logic             startR;
  logic [2:0]       drdyS;
  logic             drdyFall;
  logic             lastWord;

  assign drdyFall = drdyS[2] & ~drdyS[1];
  assign lastWord = (wordCnt == IDX_W'(FRAME_W - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_BOOT;
      cnt       <= '0;
      wordCnt   <= '0;
      flushCnt  <= 1'b0;
      startR    <= 1'b0;
      drdyS     <= 3'b111;
      resyncErr <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      drdyS  <= {drdyS[1:0], drdyN};
      startR <= 1'b0;
      if (drdyFall && state == S_FRAME) overrun <= 1'b1;
      unique case (state)
        S_BOOT: begin
          state <= S_SYNC_A;
          cnt   <= '0;
        end
        S_SYNC_A, S_SYNC_C: begin
          if (cnt == CNT_W'(SYNC_LO_CYC - 1)) begin
            cnt <= '0;
            if (state == S_SYNC_A) begin
              state <= S_SYNC_B;
            end else begin
              state    <= S_FLUSH;
              startR   <= 1'b1;
              wordCnt  <= '0;
              flushCnt <= 1'b0;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_SYNC_B: begin
          if (cnt == CNT_W'(SYNC_HI_CYC - 1)) begin
            cnt   <= '0;
            state <= S_SYNC_C;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_FLUSH, S_FRAME: begin
          if (dpDone) begin
            if (state == S_FLUSH && !flushCnt && wordCnt == '0 && !respBit)
              resyncErr <= 1'b1;
            if (lastWord) begin
              wordCnt <= '0;
              if (state == S_FLUSH && !flushCnt) begin
                flushCnt <= 1'b1;
                state    <= S_GAP;
              end else begin
                state <= S_IDLE;
              end
            end else begin
              wordCnt <= wordCnt + 1'b1;
              startR  <= 1'b1;
            end
          end
        end
        S_GAP: begin
          state  <= S_FLUSH;
          startR <= 1'b1;
        end
        S_IDLE: begin
          if (drdyFall) begin
            state   <= S_FRAME;
            startR  <= 1'b1;
            wordCnt <= '0;
          end
        end
        default: state <= S_BOOT;
      endcase
    end
  end

  assign syncN         = !(state == S_SYNC_A || state == S_SYNC_C);
  assign csN           = !(state == S_FLUSH || state == S_FRAME);
  assign cmd.wordStart = startR;
  assign cmd.emit      = (state == S_FRAME);
  assign wordIdx       = wordCnt;

  // R2
  sync_no_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    !syncN |-> csN);

  // R6
  done_in_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    dpDone |-> (!csN && wordCnt < IDX_W'(FRAME_W)));

  // R9
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);

  // R4
  resync_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    resyncErr |=> resyncErr);

endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq
  import adc_seq_pkg::*;
#(
  parameter int CH_N        = 8,
  parameter int WORD_W      = 24,
  parameter int SCLK_HALF   = 2,
  parameter int SYNC_LO_CYC = 4,
  parameter int SYNC_HI_CYC = 4,
  parameter int RESYNC_BIT  = 10
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        drdyN,
  input  logic                        miso,
  output logic                        syncN,
  output logic                        csN,
  output logic                        sclk,
  output logic [WORD_W-1:0]           wordData,
  output logic [$clog2(CH_N+1)-1:0]   wordIdx,
  output logic                        wordValid,
  output logic                        resyncErr,
  output logic                        overrun
);

  dpCmd_t            cmd;
  logic              dpDone;
  logic [WORD_W-1:0] dpWord;

  adc_seq_ctrl #(
    .CH_N        (CH_N),
    .SYNC_LO_CYC (SYNC_LO_CYC),
    .SYNC_HI_CYC (SYNC_HI_CYC)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .drdyN     (drdyN),
    .dpDone    (dpDone),
    .respBit   (dpWord[RESYNC_BIT]),
    .cmd       (cmd),
    .syncN     (syncN),
    .csN       (csN),
    .wordIdx   (wordIdx),
    .resyncErr (resyncErr),
    .overrun   (overrun)
  );

  adc_seq_shift #(
    .WORD_W    (WORD_W),
    .SCLK_HALF (SCLK_HALF)
  ) u_shift (
    .clk  (clk),
    .rstN (rstN),
    .cmd  (cmd),
    .miso (miso),
    .sclk (sclk),
    .word (dpWord),
    .done (dpDone)
  );

  assign wordData  = dpWord;
  assign wordValid = dpDone & cmd.emit;

  // R7
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);

endmodule

// File: tb/adc_frame_seq_bench.sv
module adc_frame_seq_bench;

  localparam int CH    = 8;
  localparam int WW    = 24;
  localparam int FW    = CH + 1;
  localparam int SLO   = 4;
  localparam int SHI   = 4;
  localparam int RB    = 10;
  localparam int FALLS = FW * WW;
  localparam int NV    = 6;
  // {seed, drdyN low cycles}
  localparam logic [35:0] VEC [NV] = '{
    {24'h000000, 12'd4},
    {24'hFFFFFF, 12'd3},
    {24'hAAAAAA, 12'd10},
    {24'h555555, 12'd4},
    {24'h800001, 12'd1200},
    {24'h123456, 12'd6}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, drdyN, miso;
  logic syncN, csN, sclk, wordValid, resyncErr, overrun;
  logic [WW-1:0] wordData;
  logic [$clog2(FW)-1:0] wordIdx;

  adc_frame_seq u_adc_frame_seq (
    .clk(clk), .rstN(rstN), .drdyN(drdyN), .miso(miso),
    .syncN(syncN), .csN(csN), .sclk(sclk),
    .wordData(wordData), .wordIdx(wordIdx), .wordValid(wordValid),
    .resyncErr(resyncErr), .overrun(overrun)
  );

  int checks = 0, fails = 0;
  int fnum, ptr, frameFalls, frameWords, wvTotal, nRuns, lowRun, highBetween;
  int fallsOf [8];
  int runs [4];
  logic [WW-1:0] gotD [FW];
  int gotI [FW];
  logic [WW-1:0] seed, fseed;
  bit resyncVal;
  logic sclkP = 1'b0, csP = 1'b1;

  function automatic logic [WW-1:0] modelWord(int f, int w, logic [WW-1:0] s, bit rv);
    if (w == 0)
      return 24'hA500C3 | ((f == 1 && rv) ? (24'd1 << RB) : 24'd0);
    return s ^ {6{4'(w)}};
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // converter model and monitors, all at the falling clock edge
  always @(negedge clk) begin
    logic [WW-1:0] tmp;
    if (csP && !csN) begin
      fnum++; ptr = 0; fseed = seed; frameFalls = 0; frameWords = 0;
    end
    if (!csP && csN && fnum < 8) fallsOf[fnum] = frameFalls;
    if (!sclkP && sclk && !csN) begin
      tmp  = modelWord(fnum, ptr / WW, fseed, resyncVal);
      miso = tmp[WW - 1 - (ptr % WW)];
      ptr++;
    end
    if (sclkP && !sclk) frameFalls++;
    if (wordValid) begin
      if (frameWords < FW) begin
        gotD[frameWords] = wordData;
        gotI[frameWords] = int'(wordIdx);
      end
      frameWords++;
      wvTotal++;
    end
    if (rstN) begin
      if (!syncN) lowRun++;
      else begin
        if (lowRun != 0) begin
          if (nRuns < 4) runs[nRuns] = lowRun;
          nRuns++;
          lowRun = 0;
        end
        if (nRuns == 1) highBetween++;
      end
    end
    csP = csN; sclkP = sclk;
  end

  task automatic doReset();
    rstN = 1'b0; drdyN = 1'b1; miso = 1'b0;
    fnum = 0; ptr = 0; frameFalls = 0; frameWords = 0; wvTotal = 0;
    nRuns = 0; lowRun = 0; highBetween = 0;
    for (int i = 0; i < 8; i++) fallsOf[i] = 0;
    repeat (3) @(negedge clk);
    chk("R1", "syncN", 32'(syncN), 32'd1);
    chk("R1", "csN", 32'(csN), 32'd1);
    chk("R1", "sclk", 32'(sclk), 32'd0);
    chk("R1", "wordValid", 32'(wordValid), 32'd0);
    chk("R1", "flags", {30'd0, resyncErr, overrun}, 32'd0);
    rstN = 1'b1;
  endtask

  task automatic waitFrameEnd(int target);
    while (!(fnum >= target && csN)) @(negedge clk);
  endtask

  task automatic checkFrame(string req, logic [WW-1:0] s);
    chk(req, "words per frame", 32'(frameWords), 32'(FW));
    chk("R5", "sclk falls per frame", 32'(frameFalls), 32'(FALLS));
    for (int w = 0; w < FW; w++) begin
      chk("R6", $sformatf("word %0d idx", w), 32'(gotI[w]), 32'(w));
      chk("R6", $sformatf("word %0d data", w), 32'(gotD[w]), 32'(modelWord(fnum, w, s, resyncVal)));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int startF;
    resyncVal = 1'b1;
    seed = 24'hFFFFFF;
    doReset();
    // R8: data-ready edges during the sync pattern and the first dummy frame
    repeat (5) @(negedge clk);
    drdyN = 1'b0; repeat (4) @(negedge clk); drdyN = 1'b1;
    while (fnum < 1) @(negedge clk);
    repeat (40) @(negedge clk);
    drdyN = 1'b0; repeat (4) @(negedge clk); drdyN = 1'b1;
    waitFrameEnd(2);
    repeat (60) @(negedge clk);
    chk("R2", "sync low runs", 32'(nRuns), 32'd2);
    chk("R2", "first low width", 32'(runs[0]), 32'(SLO));
    chk("R2", "high width", 32'(highBetween), 32'(SHI));
    chk("R2", "second low width", 32'(runs[1]), 32'(SLO));
    chk("R3", "dummy frame 1 falls", 32'(fallsOf[1]), 32'(FALLS));
    chk("R3", "dummy frame 2 falls", 32'(fallsOf[2]), 32'(FALLS));
    chk("R3", "no valid in dummy frames", 32'(wvTotal), 32'd0);
    chk("R8", "no extra frame", 32'(fnum), 32'd2);
    chk("R8", "overrun after startup", 32'(overrun), 32'd0);
    chk("R4", "resyncErr with bit set", 32'(resyncErr), 32'd0);

    // table of acquisition frames
    for (int k = 0; k < NV; k++) begin
      seed = VEC[k][35:12];
      startF = fnum;
      drdyN = 1'b0;
      repeat (int'(VEC[k][11:0])) @(negedge clk);
      drdyN = 1'b1;
      waitFrameEnd(startF + 1);
      repeat (20) @(negedge clk);
      checkFrame("R6", seed);
      chk("R10", "one frame per edge", 32'(fnum), 32'(startF + 1));
      chk("R9", "no overrun in clean frame", 32'(overrun), 32'd0);
      chk("R4", "later response ignored", 32'(resyncErr), 32'd0);
    end
    chk("R7", "sclk idle low", 32'(sclk), 32'd0);

    // R9: edge during a running frame
    seed = 24'h0F0F0F;
    startF = fnum;
    drdyN = 1'b0; repeat (4) @(negedge clk); drdyN = 1'b1;
    while (csN) @(negedge clk);
    repeat (30) @(negedge clk);
    drdyN = 1'b0; repeat (4) @(negedge clk); drdyN = 1'b1;
    waitFrameEnd(startF + 1);
    repeat (40) @(negedge clk);
    chk("R9", "overrun set", 32'(overrun), 32'd1);
    checkFrame("R9", seed);
    chk("R9", "no frame from late edge", 32'(fnum), 32'(startF + 1));
    seed = 24'hC3C3C3;
    startF = fnum;
    drdyN = 1'b0; repeat (4) @(negedge clk); drdyN = 1'b1;
    waitFrameEnd(startF + 1);
    repeat (20) @(negedge clk);
    checkFrame("R9", seed);
    chk("R9", "overrun sticky", 32'(overrun), 32'd1);

    // R4: resync bit clear on the first response after the strobe
    resyncVal = 1'b0;
    seed = 24'hFFFFFF;
    doReset();
    waitFrameEnd(2);
    repeat (20) @(negedge clk);
    chk("R4", "resyncErr with bit clear", 32'(resyncErr), 32'd1);
    chk("R3", "no valid in dummy frames", 32'(wvTotal), 32'd0);
    seed = 24'h3C3C3C;
    startF = fnum;
    drdyN = 1'b0; repeat (4) @(negedge clk); drdyN = 1'b1;
    waitFrameEnd(startF + 1);
    repeat (20) @(negedge clk);
    checkFrame("R6", seed);
    chk("R4", "resyncErr sticky", 32'(resyncErr), 32'd1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule